// File: doc/BRIEF.md
# Framed Two-Lane DDR Serial Word Transmitter

This block turns one 16-bit parallel word per sample period into two serial lanes. Each lane carries one byte of the word as eight bits. The bits are spaced as if they left on both edges of a data clock that runs at four times the sample rate. A frame marker runs at the sample rate, and its rising edge lines up with the first bit of each word. The receiving side uses the data clock to sample the bits and the frame marker to find word boundaries.

All timing comes from one fast internal clock that runs at 24 times the sample rate. Each serial bit lasts 3 internal cycles and each data-clock period lasts 6, so one 60° step of the data clock equals one internal cycle. A control input picks the bit order. A 3-bit phase input picks where the data clock sits against the data transitions. The default code places the clock edge in the middle of each bit (90°) by retiming it on the falling edge of the internal clock. A synchronous reset clears the held word and restarts the frame.

Top module: `ddrser_tx`

## Requirements
- R1: While `rst` is high, both lanes drive 0, `frame_o` is 1 and the word position is held at 0. The first internal cycle after reset is the first bit of a word that is all zeros.
- R2: `frame_o` has a period of 24 internal cycles. It is high for positions 0 to 11 and low for positions 12 to 23, and it rises together with the first bit of a word.
- R3: `din` is captured only on the clock edge that ends position 23 of a frame. A change of `din` at any other time has no effect on the lanes.
- R4: `lane_o[1]` carries bits 15..8 of the captured word and `lane_o[0]` carries bits 7..0.
- R5: With `lsb_first` = 0, bit slot s (positions 3s to 3s+2, s = 0..7) of lane L carries word bit 8L+7-s, so the most significant bit goes first. Each bit is held for 3 internal cycles.
- R6: With `lsb_first` = 1, bit slot s of lane L carries word bit 8L+s, so the least significant bit goes first.
- R7: For `phase_sel` codes 1 to 6, the data clock is offset by (code-1)×60° from the data transition, which is code-1 internal cycles. In this case `dclk_o` is high at position p exactly when ((p - (code-1)) mod 6) < 3.
- R8: For `phase_sel` codes 0 and 7 (the 90° default), `dclk_o` changes on the falling internal edge. In the first half of position p it equals the code-2 value for position p-1. In the second half it equals the code-2 value for position p.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock, 24 times the sample rate |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 16 | Parallel sample word |
| lsb_first | input | 1 | 0: MSB first, 1: LSB first |
| phase_sel | input | 3 | Data-clock phase: 0/7 = 90°, 1..6 = 0°..300° in 60° steps |
| lane_o | output | 2 | Serial lanes; index 1 = upper byte, index 0 = lower byte |
| frame_o | output | 1 | Frame marker, high for the first half of each word |
| dclk_o | output | 1 | Modeled DDR data clock |

## Verification
The position counter and the held word are registers. The lane bits, the frame marker and the phase codes 1 to 6 are combinational functions of those registers. They therefore change just after the rising internal edge, and the bench checks them 1 ns after that edge against a position counter that it keeps itself. A word given on `din` before the edge that ends position 23 first appears one cycle later, at position 0. The bench changes `din` every cycle, so any capture at the wrong time shows up as a wrong bit. The 90° codes also go through a falling-edge register, so for those codes the bench checks `dclk_o` a second time 1 ns after each falling edge. It expects the value one half cycle later than the 60° timing. The bench sweeps every phase code with both bit orders and includes a reset in the middle of a word.

// File: rtl/ddrser_pkg.sv
package ddrser_pkg;

    // phase code meaning
    localparam logic [2:0] PH_QUARTER_LO = 3'd0;
    localparam logic [2:0] PH_QUARTER_HI = 3'd7;
    localparam int         PH_STEPS      = 6;

    // true when the code asks for the half-cycle (90 degree) placement
    function automatic logic is_quarter(input logic [2:0] code);
        return (code == PH_QUARTER_LO) || (code == PH_QUARTER_HI);
    endfunction

    // tap index (whole internal cycles of delay) for direct codes
    function automatic logic [2:0] tap_of(input logic [2:0] code);
        return is_quarter(code) ? 3'd0 : code - 3'd1;
    endfunction

    // square-wave level of a clock with half period hp at position p delayed d
    function automatic logic wave_at(input int unsigned p, input int unsigned d,
                                     input int unsigned span, input int unsigned hp);
        return ((p + span - d) % (2 * hp)) < hp;
    endfunction

endpackage

// File: rtl/ddrser_timing.sv
module ddrser_timing #(
    parameter int FRAME_CYC = 24,
    parameter int CNT_W     = $clog2(FRAME_CYC)
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] pos,
    output logic             last,
    output logic             frame
);
    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_CYC - 1);
    localparam logic [CNT_W-1:0] HALF_POS = CNT_W'(FRAME_CYC / 2);

    logic [CNT_W-1:0] pos_q;

    always_ff @(posedge clk) begin
        if (rst)                 pos_q <= '0;
        else if (pos_q == LAST_POS) pos_q <= '0;
        else                     pos_q <= pos_q + 1'b1;
    end

    assign pos   = pos_q;
    assign last  = (pos_q == LAST_POS);
    assign frame = (pos_q < HALF_POS);

    // R2: marker edges sit at word start and word midpoint
    assert_frame_rise_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(frame) |-> pos_q == '0);
    assert_frame_fall_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(frame) |-> pos_q == HALF_POS);
    // R2: position advances by one except at the wrap
    assert_pos_step_R2: assert property (@(posedge clk) disable iff (rst)
        (pos_q != '0) |-> pos_q == $past(pos_q) + 1'b1);

endmodule

// File: rtl/ddrser_lanes.sv
module ddrser_lanes #(
    parameter int WORD_W  = 16,
    parameter int LANES   = 2,
    parameter int BIT_CYC = 3,
    parameter int CNT_W   = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              last,
    input  logic [CNT_W-1:0]  pos,
    input  logic              lsb_first,
    input  logic [WORD_W-1:0] din,
    output logic [LANES-1:0]  lane
);
    localparam int LANE_W = WORD_W / LANES;
    localparam int SLOT_W = $clog2(LANE_W);

    logic [WORD_W-1:0] word_q;
    logic [SLOT_W-1:0] slot;
    logic [SLOT_W-1:0] pick;

    always_ff @(posedge clk) begin
        if (rst)       word_q <= '0;
        else if (last) word_q <= din;
    end

    assign slot = SLOT_W'(pos / CNT_W'(BIT_CYC));
    assign pick = lsb_first ? slot : SLOT_W'(LANE_W - 1) - slot;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] byte_w;
        assign byte_w  = word_q[g*LANE_W +: LANE_W];
        assign lane[g] = byte_w[pick];
    end

    // R3: the held word only moves at the frame boundary
    assert_hold_word_R3: assert property (@(posedge clk) disable iff (rst)
        !last |=> $stable(word_q));
    // R5: a bit is held through its whole slot
    assert_bit_hold_R5: assert property (@(posedge clk) disable iff (rst)
        ((pos % CNT_W'(BIT_CYC)) != '0) && $stable(lsb_first) |-> $stable(lane));

endmodule

// File: rtl/ddrser_clkphase.sv
module ddrser_clkphase
    import ddrser_pkg::*;
#(
    parameter int FRAME_CYC = 24,
    parameter int BIT_CYC   = 3,
    parameter int CNT_W     = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] pos,
    input  logic [2:0]       phase_sel,
    output logic             dclk
);
    localparam int DCLK_CYC = 2 * BIT_CYC;
    localparam int STEP_CYC = DCLK_CYC / PH_STEPS;

    logic [PH_STEPS-1:0] tap;
    logic                half_q;

    for (genvar k = 0; k < PH_STEPS; k++) begin : g_tap
        assign tap[k] = wave_at(int'(pos), k * STEP_CYC, FRAME_CYC, BIT_CYC);
    end

    // retime the 60 degree tap by half an internal cycle
    always_ff @(negedge clk) begin
        if (rst) half_q <= 1'b0;
        else     half_q <= tap[1];
    end

    assign dclk = is_quarter(phase_sel) ? half_q : tap[tap_of(phase_sel)];

    // R8: falling-edge copy trails the 60 degree tap by half a cycle
    assert_quarter_track_R8: assert property (@(posedge clk) disable iff (rst)
        half_q == tap[1]);
    // R7: 0 degree tap rises only on a data edge
    assert_zero_align_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(tap[0]) |-> (pos % CNT_W'(DCLK_CYC)) == '0);

endmodule

// File: rtl/ddrser_tx.sv
module ddrser_tx #(
    parameter int WORD_W  = 16,
    parameter int LANES   = 2,
    parameter int BIT_CYC = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] din,
    input  logic              lsb_first,
    input  logic [2:0]        phase_sel,
    output logic [LANES-1:0]  lane_o,
    output logic              frame_o,
    output logic              dclk_o
);
    localparam int LANE_W    = WORD_W / LANES;
    localparam int FRAME_CYC = LANE_W * BIT_CYC;
    localparam int CNT_W     = $clog2(FRAME_CYC);

    logic [CNT_W-1:0] pos;
    logic             last;

    ddrser_timing #(.FRAME_CYC(FRAME_CYC), .CNT_W(CNT_W)) u_timing (
        .clk(clk), .rst(rst), .pos(pos), .last(last), .frame(frame_o)
    );

    ddrser_lanes #(.WORD_W(WORD_W), .LANES(LANES), .BIT_CYC(BIT_CYC),
                   .CNT_W(CNT_W)) u_lanes (
        .clk(clk), .rst(rst), .last(last), .pos(pos),
        .lsb_first(lsb_first), .din(din), .lane(lane_o)
    );

    ddrser_clkphase #(.FRAME_CYC(FRAME_CYC), .BIT_CYC(BIT_CYC),
                      .CNT_W(CNT_W)) u_clkphase (
        .clk(clk), .rst(rst), .pos(pos), .phase_sel(phase_sel), .dclk(dclk_o)
    );

    // R1: reset shows a cleared word at the start of a frame
    assert_reset_state_R1: assert property (@(posedge clk)
        $past(rst) |-> (lane_o == '0) && frame_o);

endmodule

// File: tb/tb_ddrser_tx.sv
`timescale 1ns/1ps
module tb_ddrser_tx;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] din = '0;
    logic        lsb_first = 1'b0;
    logic [2:0]  phase_sel = 3'd0;
    logic [1:0]  lane_o;
    logic        frame_o;
    logic        dclk_o;

    int vec = 0;
    int bad = 0;
    int exp_c = 0;
    int cyc = 0;
    logic [15:0] exp_w = '0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ddrser_tx dut (
        .clk(clk), .rst(rst), .din(din), .lsb_first(lsb_first),
        .phase_sel(phase_sel), .lane_o(lane_o), .frame_o(frame_o), .dclk_o(dclk_o)
    );

    task automatic chk(input string req, input logic act, input logic expv);
        vec++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s pos=%0d act=%0b exp=%0b", req, exp_c, act, expv);
        end
    endtask

    function automatic logic wave(input int p, input int d);
        return ((p + 24 - d) % 6) < 3;
    endfunction

    task automatic check_all();
        int slot = exp_c / 3;
        for (int l = 0; l < 2; l++) begin
            int b = lsb_first ? (l*8 + slot) : (l*8 + 7 - slot);
            // R4 lane split, R5/R6 order, R1 zero after reset
            chk(lsb_first ? "R6 lane bit" : "R5 lane bit", lane_o[l], exp_w[b]);
        end
        chk("R2 frame", frame_o, exp_c < 12);
        if (phase_sel == 3'd0 || phase_sel == 3'd7)
            chk("R8 dclk first half", dclk_o, wave(exp_c, 2));
        else
            chk("R7 dclk", dclk_o, wave(exp_c, int'(phase_sel) - 1));
    endtask

    task automatic step();
        @(posedge clk);
        if (rst) begin
            exp_c = 0;
            exp_w = '0;
        end else begin
            if (exp_c == 23) exp_w = din;
            exp_c = (exp_c + 1) % 24;
        end
        #1;
        cyc++;
        din = 16'(cyc * 40503) ^ 16'h5A3C;
        check_all();
        if (phase_sel == 3'd0 || phase_sel == 3'd7) begin
            @(negedge clk);
            #1;
            chk("R8 dclk second half", dclk_o, wave(exp_c, 1));
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        for (int i = 0; i < 4; i++) step();
        rst = 1'b0;
        for (int ph = 0; ph < 8; ph++) begin
            for (int ord = 0; ord < 2; ord++) begin
                phase_sel = 3'(ph);
                lsb_first = 1'(ord);
                for (int i = 0; i < 72; i++) step();
            end
        end
        // R1: reset in mid-word, then realignment
        phase_sel = 3'd3;
        lsb_first = 1'b0;
        for (int i = 0; i < 10; i++) step();
        rst = 1'b1;
        for (int i = 0; i < 3; i++) step();
        rst = 1'b0;
        for (int i = 0; i < 60; i++) step();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end
endmodule